// File: doc/BRIEF.md
# Write-once windowed watchdog timer

A peripheral watchdog for a system chip. A free-running slow clock enable is divided by a prescaler into ticks. Each tick decrements a 12-bit countdown. Software must restart the countdown before it runs out. If the countdown expires, the block sets an underflow status flag and, when reset generation is enabled, pulses its reset output for one clock so that the system reset controller can act on it.

The configuration word can be written only once after reset; every later write is discarded. A restart takes effect only if a single control write carries both the restart bit and the key byte 0xA5. Restarts are also checked against a window. A restart issued while the countdown is still above the window threshold is treated as a fault: the counter is not reloaded, an error flag is set, and a reset pulse is produced when resets are enabled. Setting the threshold to 0xFFF allows restarts at any time.

The register bus is a plain single-cycle select/write/read port with no wait states; writes and reads complete in the cycle they are presented. Word index 0 is the control register (write only, reads 0), word index 1 is the configuration register and word index 2 is the status register.

Top module: `wdog_win`

## Requirements
- R1: After reset the configuration reads reload=0xFFF in bits [11:0], threshold=0xFFF in bits [23:12], reset-enable=1 in bit 24, debug-halt=0 in bit 25 and disable=0 in bit 26; status reads 0 in its flag bits and the countdown reads 0xFFF in status bits [27:16]; the reset output is low.
- R2: With the block running, one tick occurs for every PRE_DIV slow-clock enables, and each tick decrements the countdown. On the tick that finds the countdown at 0, the countdown reloads, status bit 0 (underflow) sets and the reset output pulses high for exactly one clock. After a restart with reload value V, that pulse appears between PRE_DIV*V+1 and PRE_DIV*(V+1) clocks later while enables arrive every clock.
- R3: Reading the status register clears both flag bits; a second read returns 0 in them.
- R4: Only the first configuration write after reset takes effect; later writes, including ones that set the disable bit, leave the configuration and the counting unchanged.
- R5: A restart (reload of the countdown from the reload field) happens only on a control write with bit 0 set and bits [31:24] equal to 0xA5; a wrong key, or the right key without bit 0, leaves the countdown running from its current value.
- R6: A keyed restart while the countdown is greater than the threshold does not reload the countdown, sets status bit 1 (window error) and pulses the reset output for one clock when reset-enable is set; a keyed restart with the countdown at or below the threshold reloads it.
- R7: With threshold 0xFFF a keyed restart is accepted at any countdown value.
- R8: While the disable bit is set the countdown holds, restarts are ignored and the reset output stays low.
- R9: While debug-halt is set and the debug input is high, the countdown holds; with debug-halt clear the debug input has no effect.
- R10: With reset-enable clear, expiry sets the underflow flag but the reset output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | One-clock enable at the slow clock rate |
| dbg_mode | input | 1 | High while the processor is halted for debug |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Access is a write when high, a read when low |
| bus_addr | input | 2 | Word index: 0 control, 1 configuration, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| wdt_rst | output | 1 | One-clock watchdog reset pulse |

## Verification
A control or configuration write is captured at the clock edge inside the access, so a window-error reset pulse is already visible at the falling edge that ends the write task and is gone one clock later. Read data are combinational and are sampled before the edge that clears the status flags. Because the prescaler phase at the moment of a restart is unknown, expiry is timed by counting falling edges from the restart and accepting the one-tick span that R2 defines. Freezes are checked by reading the countdown twice, a known number of clocks apart.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W = 12;
  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] RESTART_KEY = 8'hA5;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CFG  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  typedef struct packed {
    logic             dis;
    logic             halt;
    logic             rst_en;
    logic [CNT_W-1:0] delta;
    logic [CNT_W-1:0] reload;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
  localparam cfg_t CFG_RESET = '{dis: 1'b0, halt: 1'b0, rst_en: 1'b1,
                                 delta: CNT_MAX, reload: CNT_MAX};
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_en,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  assign tick = run && slow_en && (pre == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
    end else if (run && slow_en) begin
      if (pre == LAST) pre <= '0;
      else             pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  assign expire = tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CNT_MAX;
    end else if (restart || expire) begin
      cnt <= reload;
    end else if (tick) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             expire,
  output cfg_t             cfg,
  output logic             locked,
  output logic             restart_ok,
  output logic             st_uf,
  output logic             st_err,
  output logic             wdt_rst
);
  logic wr_ctrl, wr_cfg, rd_stat, keyed, err_evt;

  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign wr_cfg  = bus_sel && bus_wr && (bus_addr == A_CFG);
  assign rd_stat = bus_sel && !bus_wr && (bus_addr == A_STAT);

  assign keyed      = wr_ctrl && bus_wdata[0] && !cfg.dis &&
                      (bus_wdata[31:32-KEY_W] == RESTART_KEY);
  assign err_evt    = keyed && (cnt > cfg.delta);
  assign restart_ok = keyed && !err_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= CFG_RESET;
      locked <= 1'b0;
    end else if (wr_cfg && !locked) begin
      cfg    <= cfg_t'(bus_wdata[CFG_W-1:0]);
      locked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_uf   <= 1'b0;
      st_err  <= 1'b0;
      wdt_rst <= 1'b0;
    end else begin
      st_uf   <= expire  || (st_uf  && !rd_stat);
      st_err  <= err_evt || (st_err && !rd_stat);
      wdt_rst <= cfg.rst_en && (expire || err_evt);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_CFG:   bus_rdata[CFG_W-1:0] = cfg;
        A_STAT: begin
          bus_rdata[0]     = st_uf;
          bus_rdata[1]     = st_err;
          bus_rdata[27:16] = cnt;
        end
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_win.sv
module wdog_win
  import wdog_pkg::*;
#(
  parameter int PRE_DIV = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_en,
  input  logic        dbg_mode,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst
);
  cfg_t             cfg;
  logic             locked, restart_ok, st_uf, st_err;
  logic             run, tick, expire;
  logic [CNT_W-1:0] cnt;

  assign run = !cfg.dis && !(cfg.halt && dbg_mode);

  wdog_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .run(run), .tick(tick)
  );

  wdog_count u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart_ok),
    .reload(cfg.reload), .cnt(cnt), .expire(expire)
  );

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .expire(expire), .cfg(cfg), .locked(locked),
    .restart_ok(restart_ok), .st_uf(st_uf), .st_err(st_err),
    .wdt_rst(wdt_rst)
  );
endmodule

// File: rtl/wdog_win_chk.sv
module wdog_win_chk
  import wdog_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             dbg_mode,
  input logic             wdt_rst,
  input cfg_t             cfg,
  input logic             locked,
  input logic             restart_ok,
  input logic             st_err,
  input logic [CNT_W-1:0] cnt
);
  assert_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> $stable(cfg));

  assert_dis_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.dis && locked) |=> ($stable(cnt) && !wdt_rst));

  assert_dbg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.halt && dbg_mode && !restart_ok) |=> $stable(cnt));

  assert_rst_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(cfg.rst_en));

  assert_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > $past(cnt)) |-> ($past(restart_ok) || ($past(cnt) == '0)));

  assert_win_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_err) |-> $past(cnt > cfg.delta));
endmodule

bind wdog_win wdog_win_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .wdt_rst(wdt_rst),
  .cfg(cfg), .locked(locked), .restart_ok(restart_ok), .st_err(st_err),
  .cnt(cnt)
);

// File: tb/wdog_win_test.sv
`timescale 1ns/1ps
module wdog_win_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_en = 1'b1;
  logic dbg_mode = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic wdt_rst;

  int checks = 0, fails = 0, rst_seen = 0;

  always #5 clk = ~clk;

  wdog_win #(.PRE_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .dbg_mode(dbg_mode),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst)
  );

  always @(posedge clk) if (wdt_rst) rst_seen <= rst_seen + 1;

  function automatic logic [31:0] cfgw(input logic dis, input logic halt,
      input logic ren, input logic [11:0] dl, input logic [11:0] rl);
    return {5'd0, dis, halt, ren, dl, rl};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_true(input string tag, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    dbg_mode = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rst_seen = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_cnt(output int c);
    logic [31:0] d;
    rd(2'd2, d);
    c = int'(d[27:16]);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    do_reset();
    check("R1 rst low", {31'd0, wdt_rst}, 32'd0);
    rd(2'd1, d);
    check("R1 cfg default", d, cfgw(1'b0, 1'b0, 1'b1, 12'hFFF, 12'hFFF));
    rd(2'd2, d);
    check("R1 status default", d, 32'h0FFF_0000);
  endtask

  task automatic t_expire;
    logic [31:0] d;
    int n;
    do_reset();
    wr(2'd1, cfgw(1'b0, 1'b0, 1'b1, 12'hFFF, 12'd9));
    wr(2'd0, 32'hA500_0001);
    n = 0;
    while (!wdt_rst && n < 200) begin @(negedge clk); n++; end
    check_true("R2 expiry time", n >= DIV*9+1 && n <= DIV*10, n, DIV*10);
    @(negedge clk);
    check("R2 one-clock pulse", {31'd0, wdt_rst}, 32'd0);
    rd(2'd2, d);
    check("R2 underflow flag", {31'd0, d[0]}, 32'd1);
    rd(2'd2, d);
    check("R3 clear on read", {30'd0, d[1:0]}, 32'd0);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    int c;
    do_reset();
    wr(2'd1, cfgw(1'b0, 1'b0, 1'b1, 12'hFFF, 12'd300));
    wr(2'd1, cfgw(1'b1, 1'b1, 1'b0, 12'd5, 12'd5));
    rd(2'd1, d);
    check("R4 second write ignored", d, cfgw(1'b0, 1'b0, 1'b1, 12'hFFF, 12'd300));
    repeat (60) @(negedge clk);
    rd_cnt(c);
    check_true("R4 still counting", c < 4095 - 5, c, 4090);
  endtask

  task automatic t_key;
    int c1, c2;
    do_reset();
    wr(2'd1, cfgw(1'b0, 1'b0, 1'b1, 12'hFFF, 12'd200));
    wr(2'd0, 32'hA500_0001);
    rd_cnt(c1);
    check_true("R7 restart at 0xFFF accepted", c1 >= 199 && c1 <= 200, c1, 200);
    repeat (80) @(negedge clk);
    wr(2'd0, 32'h5A00_0001);
    rd_cnt(c2);
    check_true("R5 wrong key ignored", c2 < 195, c2, 180);
    wr(2'd0, 32'hA500_0000);
    rd_cnt(c2);
    check_true("R5 no restart bit ignored", c2 < 195, c2, 180);
    check_true("R5 no reset", rst_seen == 0, rst_seen, 0);
  endtask

  task automatic t_window;
    logic [31:0] d;
    int c, guard;
    do_reset();
    wr(2'd1, cfgw(1'b0, 1'b0, 1'b1, 12'd50, 12'd100));
    wr(2'd0, 32'hA500_0001);
    check("R6 early restart reset", {31'd0, wdt_rst}, 32'd1);
    @(negedge clk);
    check("R6 reset one clock", {31'd0, wdt_rst}, 32'd0);
    rd(2'd2, d);
    check("R6 error flag", {30'd0, d[1:0]}, 32'd2);
    check_true("R6 not reloaded", int'(d[27:16]) > 100, int'(d[27:16]), 4095);
    c = 4095; guard = 0;
    while (c > 50 && guard < 20000) begin rd_cnt(c); guard++; end
    wr(2'd0, 32'hA500_0001);
    rd(2'd2, d);
    check_true("R6 in-window restart", int'(d[27:16]) >= 99 && int'(d[27:16]) <= 100,
               int'(d[27:16]), 100);
    check("R6 no new error", {31'd0, d[1]}, 32'd0);
  endtask

  task automatic t_disable;
    int c1, c2;
    do_reset();
    wr(2'd1, cfgw(1'b1, 1'b0, 1'b1, 12'hFFF, 12'd2));
    rd_cnt(c1);
    repeat (100) @(negedge clk);
    wr(2'd0, 32'hA500_0001);
    rd_cnt(c2);
    check("R8 count held", 32'(c2), 32'(c1));
    check_true("R8 no reset", rst_seen == 0, rst_seen, 0);
  endtask

  task automatic t_debug;
    int c1, c2, c3;
    do_reset();
    wr(2'd1, cfgw(1'b0, 1'b1, 1'b1, 12'hFFF, 12'hFFF));
    dbg_mode = 1'b1;
    rd_cnt(c1);
    repeat (50) @(negedge clk);
    rd_cnt(c2);
    check("R9 halted in debug", 32'(c2), 32'(c1));
    dbg_mode = 1'b0;
    repeat (50) @(negedge clk);
    rd_cnt(c3);
    check_true("R9 resumes", c3 < c1, c3, c1 - 12);
    do_reset();
    wr(2'd1, cfgw(1'b0, 1'b0, 1'b1, 12'hFFF, 12'hFFF));
    dbg_mode = 1'b1;
    rd_cnt(c1);
    repeat (50) @(negedge clk);
    rd_cnt(c2);
    check_true("R9 no halt when bit clear", c2 < c1, c2, c1 - 12);
    dbg_mode = 1'b0;
  endtask

  task automatic t_noen;
    logic [31:0] d;
    do_reset();
    wr(2'd1, cfgw(1'b0, 1'b0, 1'b0, 12'hFFF, 12'd3));
    wr(2'd0, 32'hA500_0001);
    repeat (30) @(negedge clk);
    check_true("R10 no reset output", rst_seen == 0, rst_seen, 0);
    rd(2'd2, d);
    check("R10 underflow flag", {31'd0, d[0]}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_expire();
    t_lock();
    t_key();
    t_window();
    t_disable();
    t_debug();
    t_noen();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule